// File: doc/BRIEF.md
# Masked Channel Enable and Suspend Register Block

This block holds the run-control state of a multi-channel DMA engine: one enable bit and one suspend bit per channel. Software reaches it over a plain 32-bit register bus. Every writable control bit has a companion write-enable bit, and a write changes only the bits whose companion is 1. Software can therefore start, stop, pause or resume one channel with a single write. It never has to read the register first, and it cannot disturb the other channels.

The parameter `NUM_CH` (1 to 16) picks the register layout. With eight channels or fewer, the enable and suspend fields share the enable register. With more than eight channels, the write-enable field moves up and suspend control gets a register of its own. The channel datapath drives two inputs back into the block. A per-channel completion pulse clears that channel's enable bit. A per-channel suspended-acknowledge sets a sticky status bit, which software polls before it treats the channel as paused. The status bit is cleared by writing 1 to it.

All register fields are plain control and status. No stream interface exists and no back-pressure applies. A bus write takes effect at the clock edge where `reg_wr_i` is high, and read data is a combinational function of `reg_addr_i`.

Top module: `dma_chctl_regs`

## Requirements
- R1: After reset, every enable, suspend and suspended-status bit is 0, and every register reads 0.
- R2: The layout is fixed by `NUM_CH`: the compact layout applies when `NUM_CH` is 8 or less, and the extended layout applies otherwise.
- R3: In the compact layout, the enable register at 0x018 carries channel c's enable value at bit c, its enable write-enable at bit 8+c, its suspend value at bit 16+c and its suspend write-enable at bit 24+c. Register 0x020 ignores writes and reads 0.
- R4: In the extended layout, the enable register at 0x018 carries the enable value at bit c and the enable write-enable at bit 16+c. The suspend register at 0x020 carries the suspend value at bit c and the suspend write-enable at bit 16+c. A write to 0x018 never changes a suspend bit.
- R5: A write updates a channel's enable or suspend bit to the written value only when that bit's write-enable is 1 in the same write. All other bits keep their state. `ch_en_o` and `ch_susp_o` show the stored bits from the cycle after the write.
- R6: Write-enable bit positions and bits beyond the channel count read as 0, and writes to those bit positions are ignored. Enable and suspend bit positions read back their stored values.
- R7: When `ch_susp_ack_i[c]` is 1 at a clock edge while channel c is both enabled and suspended, its suspended-status bit reads 1 from the following cycle on. An acknowledge for a channel that is not both enabled and suspended is ignored.
- R8: A suspended-status bit stays set until software writes 1 to bit c of the clear register at 0x038. Resume and disable leave it set. A new set in the same cycle as a clear wins.
- R9: `ch_done_i[c]` clears channel c's enable bit at that clock edge, even when a software write in the same cycle sets it.
- R10: The suspended-status bits read at 0x030, bit c for channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| ch_done_i | input | NUM_CH | Per-channel completion pulse, clears the enable bit |
| ch_susp_ack_i | input | NUM_CH | Per-channel suspended acknowledge from the datapath |
| ch_en_o | output | NUM_CH | Stored channel enable bits |
| ch_susp_o | output | NUM_CH | Stored channel suspend bits |

## Verification
Writes, completion pulses and acknowledges all act at one clock edge, and each has a single register in its path. The enable outputs, suspend outputs and status bits therefore change exactly one cycle after the stimulus. The bench drives each stimulus on a falling edge, removes it just after the next rising edge, and samples the outputs there. Read data has no register in its path. For each read the bench changes the address and checks the data a short settle time later, within the same cycle.

// File: rtl/dma_chctl_pkg.sv
package dma_chctl_pkg;
  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 8;
  localparam int MAX_CH     = 16;
  localparam int COMPACT_CH = 8;

  localparam logic [ADDR_W-1:0] OFS_CHEN   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CHSUSP = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STS    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_STSCLR = 8'h38;

  // Compact-layout field bases
  localparam int CMP_EN_WE   = 8;
  localparam int CMP_SUSP    = 16;
  localparam int CMP_SUSP_WE = 24;
  // Extended-layout field bases
  localparam int EXT_WE      = 16;

  function automatic bit layout_is_ext(int n);
    return n > COMPACT_CH;
  endfunction
endpackage

// File: rtl/dma_chctl_mbits.sv
module dma_chctl_mbits #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] val_i,
  input  logic [N-1:0] we_i,
  input  logic [N-1:0] hw_clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (wr_i) q_nxt = (q_r & ~we_i) | (val_i & we_i);
    q_nxt = q_nxt & ~hw_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R5
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(we_i & {N{wr_i}}) & ~$past(hw_clr_i)) == '0));

  // R9
  hw_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr_i != '0) |=> ((q_o & $past(hw_clr_i)) == '0));
endmodule

// File: rtl/dma_chctl_sticky.sv
module dma_chctl_sticky #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= (q_r & ~clr_i) | set_i;
  end

  assign q_o = q_r;

  // R7
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R8
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/dma_chctl_regs.sv
module dma_chctl_regs
  import dma_chctl_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic [NUM_CH-1:0] ch_susp_ack_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic [NUM_CH-1:0] ch_susp_o
);
  localparam bit EXT = layout_is_ext(NUM_CH);

  logic              wr_chen, wr_clr, susp_wr;
  logic [NUM_CH-1:0] en_we, susp_val, susp_we;
  logic [NUM_CH-1:0] en_q, susp_q, sts_q, sts_set, sts_clr;
  logic [BUS_W-1:0]  rd_chen, rd_susp;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign wr_chen = reg_wr_i && (reg_addr_i == OFS_CHEN);
  assign wr_clr  = reg_wr_i && (reg_addr_i == OFS_STSCLR);

  generate
    if (EXT) begin : g_ext
      assign en_we    = reg_wdata_i[EXT_WE +: NUM_CH];
      assign susp_wr  = reg_wr_i && (reg_addr_i == OFS_CHSUSP);
      assign susp_val = reg_wdata_i[0 +: NUM_CH];
      assign susp_we  = reg_wdata_i[EXT_WE +: NUM_CH];
      always_comb begin
        rd_chen = '0;
        rd_chen[0 +: NUM_CH] = en_q;
        rd_susp = '0;
        rd_susp[0 +: NUM_CH] = susp_q;
      end
    end else begin : g_cmp
      assign en_we    = reg_wdata_i[CMP_EN_WE +: NUM_CH];
      assign susp_wr  = wr_chen;
      assign susp_val = reg_wdata_i[CMP_SUSP +: NUM_CH];
      assign susp_we  = reg_wdata_i[CMP_SUSP_WE +: NUM_CH];
      always_comb begin
        rd_chen = '0;
        rd_chen[0 +: NUM_CH]        = en_q;
        rd_chen[CMP_SUSP +: NUM_CH] = susp_q;
        rd_susp = '0;
      end
    end
  endgenerate

  dma_chctl_mbits #(.N(NUM_CH)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_chen),
    .val_i(reg_wdata_i[0 +: NUM_CH]), .we_i(en_we),
    .hw_clr_i(ch_done_i), .q_o(en_q)
  );

  dma_chctl_mbits #(.N(NUM_CH)) u_susp (
    .clk(clk), .rst_n(rst_n), .wr_i(susp_wr),
    .val_i(susp_val), .we_i(susp_we),
    .hw_clr_i('0), .q_o(susp_q)
  );

  assign sts_set = ch_susp_ack_i & en_q & susp_q;
  assign sts_clr = wr_clr ? reg_wdata_i[0 +: NUM_CH] : '0;

  dma_chctl_sticky #(.N(NUM_CH)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i(sts_set), .clr_i(sts_clr), .q_o(sts_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_CHEN:   reg_rdata_o = rd_chen;
      OFS_CHSUSP: reg_rdata_o = rd_susp;
      OFS_STS:    reg_rdata_o[0 +: NUM_CH] = sts_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign ch_en_o   = en_q;
  assign ch_susp_o = susp_q;
endmodule

// File: tb/dma_chctl_regs_tb_top.sv
module dma_chctl_regs_tb_top;
  localparam int NX = 12;
  localparam int NC = 6;

  typedef struct packed {
    logic          wr;
    logic [7:0]    addr;
    logic [31:0]   wd;
    logic [NX-1:0] done;
    logic [NX-1:0] ack;
    logic [NX-1:0] en;
    logic [NX-1:0] susp;
    logic [NX-1:0] sts;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h18, 32'h0003_0003, 12'h000, 12'h000, 12'h003, 12'h000, 12'h000}, // R4 R5 enable ch0,1
    '{1'b1, 8'h18, 32'h0006_0004, 12'h000, 12'h000, 12'h005, 12'h000, 12'h000}, // R5 ch1 off, ch2 on
    '{1'b1, 8'h18, 32'h0000_0FFF, 12'h000, 12'h000, 12'h005, 12'h000, 12'h000}, // R5 no write-enable
    '{1'b1, 8'h18, 32'hF000_F000, 12'h000, 12'h000, 12'h005, 12'h000, 12'h000}, // R6 beyond channel count
    '{1'b1, 8'h18, 32'h0F00_0F00, 12'h000, 12'h000, 12'hF05, 12'h000, 12'h000}, // R4 upper channels, no suspend
    '{1'b1, 8'h20, 32'h0005_0005, 12'h000, 12'h000, 12'hF05, 12'h005, 12'h000}, // R4 suspend ch0,2
    '{1'b0, 8'h00, 32'h0,         12'h000, 12'h007, 12'hF05, 12'h005, 12'h005}, // R7 ack, ch1 ignored
    '{1'b1, 8'h20, 32'h0001_0000, 12'h000, 12'h000, 12'hF05, 12'h004, 12'h005}, // R8 resume keeps status
    '{1'b1, 8'h38, 32'h0000_0001, 12'h000, 12'h000, 12'hF05, 12'h004, 12'h004}, // R8 clear ch0
    '{1'b1, 8'h18, 32'h0004_0004, 12'h004, 12'h000, 12'hF01, 12'h004, 12'h004}, // R9 done beats write
    '{1'b1, 8'h18, 32'h0F00_0000, 12'h000, 12'h000, 12'h001, 12'h004, 12'h004}, // R5 disable ch8..11
    '{1'b0, 8'h00, 32'h0,         12'h000, 12'h004, 12'h001, 12'h004, 12'h004}, // R7 ack on disabled ch2
    '{1'b1, 8'h38, 32'h0000_0004, 12'h000, 12'h000, 12'h001, 12'h004, 12'h000}  // R8 clear ch2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          x_wr, c_wr;
  logic [7:0]    x_addr, c_addr;
  logic [31:0]   x_wd, c_wd, x_rd, c_rd;
  logic [NX-1:0] x_done, x_ack, x_en, x_susp;
  logic [NC-1:0] c_done, c_ack, c_en, c_susp;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  dma_chctl_regs #(.NUM_CH(NX)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(x_wr), .reg_addr_i(x_addr),
    .reg_wdata_i(x_wd), .reg_rdata_o(x_rd), .ch_done_i(x_done),
    .ch_susp_ack_i(x_ack), .ch_en_o(x_en), .ch_susp_o(x_susp)
  );

  dma_chctl_regs #(.NUM_CH(NC)) dut_c (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(c_wr), .reg_addr_i(c_addr),
    .reg_wdata_i(c_wd), .reg_rdata_o(c_rd), .ch_done_i(c_done),
    .ch_susp_ack_i(c_ack), .ch_en_o(c_en), .ch_susp_o(c_susp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic c_write(input logic [7:0] a, input logic [31:0] d, input logic [NC-1:0] dn);
    @(negedge clk);
    c_wr = 1'b1; c_addr = a; c_wd = d; c_done = dn;
    @(posedge clk); #1;
    c_wr = 1'b0; c_done = '0;
  endtask

  task automatic x_read(input logic [7:0] a, input string req, input logic [31:0] exp);
    x_addr = a; #1;
    chk(req, x_rd, exp);
  endtask

  task automatic c_read(input logic [7:0] a, input string req, input logic [31:0] exp);
    c_addr = a; #1;
    chk(req, c_rd, exp);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    x_wr = 0; x_addr = 0; x_wd = 0; x_done = 0; x_ack = 0;
    c_wr = 0; c_addr = 0; c_wd = 0; c_done = 0; c_ack = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 en during reset", {20'b0, x_en}, 32'h0);
    chk("R1 susp during reset", {20'b0, x_susp}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    x_read(8'h18, "R1 chen read", 32'h0);
    x_read(8'h20, "R1 susp read", 32'h0);
    x_read(8'h30, "R1 R10 status read", 32'h0);

    // Vector walk on the extended (R2) instance
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      x_wr = VECS[i].wr; x_addr = VECS[i].addr; x_wd = VECS[i].wd;
      x_done = VECS[i].done; x_ack = VECS[i].ack;
      @(posedge clk); #1;
      x_wr = 1'b0; x_done = '0; x_ack = '0;
      chk($sformatf("R5 vec%0d en", i), {20'b0, x_en}, {20'b0, VECS[i].en});
      chk($sformatf("R4 vec%0d susp", i), {20'b0, x_susp}, {20'b0, VECS[i].susp});
      x_read(8'h30, $sformatf("R10 vec%0d status", i), {20'b0, VECS[i].sts});
    end

    // R6 readback: write-enable positions read 0
    x_read(8'h18, "R6 ext chen readback", 32'h0000_0001);
    x_read(8'h20, "R6 ext susp readback", 32'h0000_0004);

    // Compact (R2 R3) instance
    c_write(8'h18, 32'h0101_0303, '0);
    chk("R3 compact en", {26'b0, c_en}, 32'h03);
    chk("R3 compact susp", {26'b0, c_susp}, 32'h01);
    c_read(8'h18, "R6 compact chen readback", 32'h0001_0003);
    c_write(8'h20, 32'h003F_003F, '0);
    chk("R3 compact 0x020 ignored", {26'b0, c_susp}, 32'h01);
    c_read(8'h20, "R3 compact 0x020 reads 0", 32'h0);
    c_write(8'h18, 32'h0100_0000, '0);
    chk("R3 compact resume", {26'b0, c_susp}, 32'h00);
    chk("R5 compact en kept", {26'b0, c_en}, 32'h03);
    c_write(8'h00, 32'h0, 6'h02);
    chk("R9 compact done", {26'b0, c_en}, 32'h01);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule